// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 32-bit virtual address into a 32-bit physical address by consulting a flat page table kept in memory. The virtual address is cut into a page number (upper bits) and a byte offset (low 12 bits, for 4 KB pages). The page number is first compared against a table length register. If it lies inside the table, the block reads one table entry from memory at the base register plus four times the page number. It then inspects that entry and answers with either the frame number joined to the untouched offset, or a fault with a two-bit cause.

Software programs the table base and the table length through a small register-write port. Translations arrive on a valid/ready request port carrying the address and a write flag. Only one request is in flight at a time. The answer waits on a valid/ready response port until it is taken.

Top module: `pt_xlate`

## Requirements
- R1: For an access that passes every check, the physical address equals the entry's frame field (entry bits [31:12]) followed by the low 12 bits of the virtual address, and the cause is 2'b00 with the fault flag low.
- R2: An in-bounds request makes exactly one memory read, at address base + 4 * page number, with the page number taken from virtual address bits [31:12] and the sum wrapping at 32 bits.
- R3: A page number greater than or equal to the table length answers with cause 2'b01 and makes no memory read.
- R4: An entry whose valid bit (bit 1) is 0 answers with cause 2'b10, whatever the write flag and the read-only bit are.
- R5: A write to a valid entry whose read-only bit (bit 0) is 1 answers with cause 2'b11. A read of the same entry succeeds.
- R6: Every faulting answer raises the fault flag and drives the physical address as zero.
- R7: The request ready signal is high when idle and stays low from the accepted request until the response is taken.
- R8: The response stays valid, with an unchanged address and cause, until the response ready signal is seen high.
- R9: A register write with select 0 loads the table base and with select 1 loads the table length (low 21 bits). Both reset to zero, so after reset every request takes the bounds fault.
- R10: After reset the block is idle: request ready high, response valid low, no memory read requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | Register select: 0 table base, 1 table length |
| cfgWrData | input | 32 | Register write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| rspValid | output | 1 | Translation answer valid |
| rspReady | input | 1 | Consumer takes the answer |
| rspPaddr | output | 32 | Physical address, zero on fault |
| rspFault | output | 1 | Answer is a fault |
| rspCause | output | 2 | 00 ok, 01 bounds, 10 invalid, 11 write-protect |
| memRdReq | output | 1 | One-cycle memory read request |
| memRdAddr | output | 32 | Address of the table entry to read |
| memRdDataValid | input | 1 | Memory read data valid, at least one cycle after the request |
| memRdData | input | 32 | Table entry returned by memory |

## Verification
The bench builds the block with its default widths: 32-bit addresses, 4 KB pages and 32-bit entries. It programs a short table length of eight and sweeps page numbers across and past that edge, with reads and writes, under two base values. One of those bases makes the entry address wrap past the top of the address space. The bench memory derives each entry arithmetically from the requested address, so the valid and read-only combinations all appear. Further runs take the length to zero and to the full 2^20 entries, which puts the largest page number and the reset state within reach.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_BOUNDS  = 2'b01,
    CAUSE_INVALID = 2'b10,
    CAUSE_WPROT   = 2'b11
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch the incoming request
    logic loadBounds;  // record a bounds fault
    logic loadEntry;   // evaluate the returned table entry
  } ctlStrobe_t;

endpackage

// File: rtl/pt_xlate_ctrl.sv
module pt_xlate_ctrl
  import pt_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       outOfBounds,
  input  logic       memRdDataValid,
  input  logic       rspReady,
  output logic       reqReady,
  output logic       memRdReq,
  output logic       rspValid,
  output ctlStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_e;

  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (outOfBounds) begin
            strobe.loadBounds = 1'b1;
            stateD = ST_RESP;
          end else begin
            stateD = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: begin
        if (memRdDataValid) begin
          strobe.loadEntry = 1'b1;
          stateD = ST_RESP;
        end
      end
      ST_RESP: begin
        if (rspReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memRdReq = (stateQ == ST_ISSUE);
  assign rspValid = (stateQ == ST_RESP);

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);  // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);  // R8

  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memRdReq);  // R7

endmodule

// File: rtl/pt_xlate_dp.sv
module pt_xlate_dp
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRY_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgSel,
  input  logic [PA_W-1:0]    cfgWrData,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  input  logic [ENTRY_W-1:0] memRdData,
  input  ctlStrobe_t         strobe,
  input  logic               rspValidIn,
  input  logic               rspReadyIn,
  output logic               outOfBounds,
  output logic [PA_W-1:0]    memRdAddr,
  output logic [PA_W-1:0]    rspPaddr,
  output logic [1:0]         rspCause
);

  localparam int VPN_W   = VA_W - PAGE_BITS;
  localparam int FRAME_W = PA_W - PAGE_BITS;
  localparam int LEN_W   = VPN_W + 1;
  localparam int VALID_B = 1;
  localparam int RO_B    = 0;

  logic [PA_W-1:0]  baseQ;
  logic [LEN_W-1:0] lengthQ;
  logic [VA_W-1:0]  vaddrQ;
  logic             writeQ;
  logic [PA_W-1:0]  paddrQ;
  cause_e           causeQ;

  logic [VPN_W-1:0]   vpnIn;
  logic [VPN_W-1:0]   vpnQ;
  logic [FRAME_W-1:0] entryFrame;
  logic               entryValid;
  logic               entryRo;
  logic               unusedEntryBits;
  logic               unusedCfgBits;

  assign vpnIn       = reqVaddr[VA_W-1:PAGE_BITS];
  assign vpnQ        = vaddrQ[VA_W-1:PAGE_BITS];
  assign outOfBounds = ({1'b0, vpnIn} >= lengthQ);
  assign memRdAddr   = baseQ + (PA_W'(vpnQ) << 2);

  assign entryFrame = memRdData[ENTRY_W-1 -: FRAME_W];
  assign entryValid = memRdData[VALID_B];
  assign entryRo    = memRdData[RO_B];

  generate
    if (ENTRY_W - FRAME_W > 2) begin : g_spare
      assign unusedEntryBits = ^memRdData[ENTRY_W-FRAME_W-1:2];
    end else begin : g_nospare
      assign unusedEntryBits = 1'b0;
    end
    if (PA_W > LEN_W) begin : g_cfgspare
      assign unusedCfgBits = ^cfgWrData[PA_W-1:LEN_W];
    end else begin : g_cfgnospare
      assign unusedCfgBits = 1'b0;
    end
  endgenerate

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      lengthQ <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) lengthQ <= cfgWrData[LEN_W-1:0];
      else        baseQ   <= cfgWrData;
    end
  end

  // request capture and answer formation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ <= '0;
      writeQ <= 1'b0;
      paddrQ <= '0;
      causeQ <= CAUSE_NONE;
    end else begin
      if (strobe.capture) begin
        vaddrQ <= reqVaddr;
        writeQ <= reqWrite;
      end
      if (strobe.loadBounds) begin
        paddrQ <= '0;
        causeQ <= CAUSE_BOUNDS;
      end else if (strobe.loadEntry) begin
        if (!entryValid) begin
          paddrQ <= '0;
          causeQ <= CAUSE_INVALID;
        end else if (writeQ && entryRo) begin
          paddrQ <= '0;
          causeQ <= CAUSE_WPROT;
        end else begin
          paddrQ <= {entryFrame, vaddrQ[PAGE_BITS-1:0]};
          causeQ <= CAUSE_NONE;
        end
      end
    end
  end

  assign rspPaddr = paddrQ;
  assign rspCause = causeQ;

  AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    rspValidIn && causeQ == CAUSE_NONE |-> rspPaddr[PAGE_BITS-1:0] == vaddrQ[PAGE_BITS-1:0]);  // R1

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValidIn && causeQ != CAUSE_NONE |-> rspPaddr == '0);  // R6

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValidIn && !rspReadyIn |=> $stable(rspPaddr) && $stable(rspCause));  // R8

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRY_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgSel,
  input  logic [PA_W-1:0]    cfgWrData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [PA_W-1:0]    rspPaddr,
  output logic               rspFault,
  output logic [1:0]         rspCause,
  output logic               memRdReq,
  output logic [PA_W-1:0]    memRdAddr,
  input  logic               memRdDataValid,
  input  logic [ENTRY_W-1:0] memRdData
);

  ctlStrobe_t strobe;
  logic       outOfBounds;

  pt_xlate_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .outOfBounds    (outOfBounds),
    .memRdDataValid (memRdDataValid),
    .rspReady       (rspReady),
    .reqReady       (reqReady),
    .memRdReq       (memRdReq),
    .rspValid       (rspValid),
    .strobe         (strobe)
  );

  pt_xlate_dp #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .ENTRY_W   (ENTRY_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgSel      (cfgSel),
    .cfgWrData   (cfgWrData),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .memRdData   (memRdData),
    .strobe      (strobe),
    .rspValidIn  (rspValid),
    .rspReadyIn  (rspReady),
    .outOfBounds (outOfBounds),
    .memRdAddr   (memRdAddr),
    .rspPaddr    (rspPaddr),
    .rspCause    (rspCause)
  );

  assign rspFault = (rspCause != 2'b00);

endmodule

// File: tb/test_pt_xlate.sv
module test_pt_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPaddr;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdDataValid = 1'b0;
  logic [31:0] memRdData = '0;

  int checks = 0;
  int failures = 0;
  int readCount = 0;
  int cycles = 0;
  logic [31:0] lastAddr = '0;
  logic [31:0] curBase = '0;
  bit pend = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pt_xlate i_pt_xlate (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .rspCause(rspCause), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdDataValid(memRdDataValid), .memRdData(memRdData)
  );

  // table entry for index n, computed arithmetically
  function automatic logic [31:0] entryOf(input logic [31:0] idx);
    logic [19:0] frame;
    frame = 20'((idx * 37 + 5) & 32'hFFFFF);
    return {frame, 10'b0, ((idx % 4) != 3), ((idx % 3) == 1)};
  endfunction

  // memory model: answers one cycle after the request
  always @(negedge clk) begin
    if (pend) begin
      memRdDataValid = 1'b1;
      memRdData = entryOf((lastAddr - curBase) >> 2);
      pend = 1'b0;
    end else begin
      memRdDataValid = 1'b0;
    end
    if (rstN && memRdReq) begin
      pend = 1'b1;
      lastAddr = memRdAddr;
      readCount++;
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", what, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (!sel) curBase = data;
  endtask

  // one translation with expected values worked out from the requirements
  task automatic xlate(input logic [31:0] va, input bit wr, input logic [31:0] len);
    logic [31:0] vpn, ent, expPaddr, holdPaddr;
    logic [1:0]  expCause;
    int rc0, waitCnt;
    bit expRead;
    vpn = va >> 12;
    expRead = (vpn < len);
    expPaddr = '0;
    if (!expRead) expCause = 2'b01;
    else begin
      ent = entryOf(vpn);
      if (!ent[1]) expCause = 2'b10;
      else if (wr && ent[0]) expCause = 2'b11;
      else begin
        expCause = 2'b00;
        expPaddr = {ent[31:12], va[11:0]};
      end
    end
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    rc0 = readCount;
    chk(reqReady, "R7 ready while idle", 32'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R7 ready low while busy", 32'(reqReady), 0);
    waitCnt = 0;
    while (!rspValid && waitCnt < 40) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(rspValid, "R7 response arrives", 32'(rspValid), 1);
    case (expCause)
      2'b00: chk(rspCause == 2'b00 && !rspFault, "R1 ok cause/flag", {rspFault, 29'b0, rspCause}, 0);
      2'b01: chk(rspCause == 2'b01, "R3 bounds cause", 32'(rspCause), 1);
      2'b10: chk(rspCause == 2'b10, "R4 invalid cause", 32'(rspCause), 2);
      default: chk(rspCause == 2'b11, "R5 write-protect cause", 32'(rspCause), 3);
    endcase
    if (expCause == 2'b00) chk(rspPaddr == expPaddr, "R1 physical address", rspPaddr, expPaddr);
    else chk(rspPaddr == 0 && rspFault, "R6 fault flag and zero address", rspPaddr, 0);
    if (expRead) begin
      chk(readCount - rc0 == 1, "R2 one memory read", 32'(readCount - rc0), 1);
      chk(lastAddr == curBase + (vpn << 2), "R2 entry address", lastAddr, curBase + (vpn << 2));
    end else begin
      chk(readCount == rc0, "R3 no memory read on bounds", 32'(readCount - rc0), 0);
    end
    holdPaddr = rspPaddr;
    @(negedge clk);
    chk(rspValid && rspPaddr == holdPaddr && !reqReady, "R8 response held", rspPaddr, holdPaddr);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R7 idle after response taken", {31'b0, rspValid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady && !rspValid && !memRdReq, "R10 reset state",
        {29'b0, reqReady, rspValid, memRdReq}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    // R9: zero reset length gives bounds fault on page 0
    xlate(32'h0000_0ABC, 1'b0, 0);
    // R9: base at select 0, length at select 1; sweep across the table end
    begin
      logic [31:0] bases [2];
      bases[0] = 32'h0004_0000;
      bases[1] = 32'hFFFF_FFF0;
      for (int b = 0; b < 2; b++) begin
        cfgWrite(1'b0, bases[b]);
        cfgWrite(1'b1, 32'd8);
        for (int v = 0; v < 10; v++) begin
          for (int w = 0; w < 2; w++) begin
            xlate({20'(v), 12'((v * 679 + w * 3 + b) & 32'hFFF)}, w[0], 8);
          end
        end
      end
    end
    // full-size table: largest page numbers in bounds
    cfgWrite(1'b0, 32'h1000_0000);
    cfgWrite(1'b1, 32'h0010_0000);
    for (int w = 0; w < 2; w++) begin
      xlate(32'hFFFF_F123, w[0], 32'h0010_0000);
      xlate(32'hFFFF_EFFF, w[0], 32'h0010_0000);
      xlate(32'hFFFF_D000, w[0], 32'h0010_0000);
    end
    // edge of a 4096-entry table
    cfgWrite(1'b1, 32'h0000_1000);
    xlate(32'h00FF_F456, 1'b0, 32'h1000);
    xlate(32'h0100_0456, 1'b0, 32'h1000);
    // length back to zero: every page out of bounds
    cfgWrite(1'b1, 32'h0);
    xlate(32'h0000_0010, 1'b1, 0);
    finishRun();
  end

endmodule